// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

This block holds six independent down-counting timers behind a 32-bit register port with single-cycle writes and combinational reads. Each timer has a control word, a reload value and a live counter. It picks one of four externally generated tick-enable inputs as its clock, and it divides those ticks by a power of two before they reach the counter. A timer either repeats, reloading itself each time it expires, or fires once and then switches itself off.

Every expiry sets that timer's bit in a shared status register. Software clears status bits by writing ones to them. A shared enable register masks which status bits reach the six interrupt outputs. Software programs the reload value first, then writes a control word that can load the counter and start the timer in the same write. It services the interrupt by clearing the status bit.

Top module: `interval_timer_bank`

## Requirements
- R1: After reset, the interrupt-enable and status registers read 0 and every irq output is low. Every channel's control register reads 0x04, which selects source 1 with the timer stopped. Every interval register and every count register reads 0.
- R2: The interrupt-enable register is at offset 0x000 and the status register is at 0x004. Channel i (0..5) occupies the window at 0x10*(i+1), with control at +0x0, interval at +0x4 and count at +0x8. A read of any other offset returns 0, and a write to it changes no register. Writes to a count register are also ignored.
- R3: Control bit 0 is the enable bit, bit 1 is the reload bit, bits [3:2] select the source, bits [6:4] hold the prescaler exponent n, and bit 7 selects one-shot mode. The register stores bits [7:0] as written and reads 0 in bits [31:8]. When a control write has bit 1 set, the channel's count takes the interval value at that clock edge.
- R4: While bit 0 is set, a channel makes one decrement event for every 2^n ticks of its selected source. A control write restarts this tick division from zero. While bit 0 is clear, ticks have no effect and the count holds.
- R5: A decrement event that finds the count at 0 is an expiry, and it sets the channel's status bit. In periodic mode (bit 7 clear), the count then reloads from the interval value. At any other decrement event the count goes down by 1.
- R6: In one-shot mode (bit 7 set), an expiry clears control bit 0, the other control bits keep their values, and the count stays at 0.
- R7: irq[i] is high exactly when status bit i and enable bit i are both 1. The enable register stores write-data bits [5:0].
- R8: A write to the status register clears each bit written as 1 and leaves every bit written as 0 unchanged. If an expiry happens in the same cycle as that write, the expiry's bit ends up set.
- R9: A write to an interval register changes the value used by later reloads and leaves the live count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe; the register is written at the clock edge |
| bus_addr | input | 10 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_tick | input | 4 | One tick-enable pulse line per clock source |
| irq | output | 6 | One interrupt line per channel, masked by the enable register |

## Verification
The bench targets the case where a status clear and an expiry land in the same cycle; a design that let the clear win would lose that interrupt. It targets one-shot expiry; a design that kept the enable bit set, or that reloaded the count, would fire again. It targets ticks arriving while a channel is stopped and ticks between prescaler wraps; a design that counted them would drift or expire early. It also targets writes to unmapped offsets and to the count register; a design with loose decode would corrupt a neighbouring register, and the bench would then read back wrong data.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CTRL_W      = 8;
    localparam int SRC_W       = 2;
    localparam int EXP_W       = 3;
    localparam int CTL_EN      = 0;
    localparam int CTL_RELOAD  = 1;
    localparam int CTL_SRC_LO  = 2;
    localparam int CTL_EXP_LO  = 4;
    localparam int CTL_ONESHOT = 7;
    localparam logic [CTRL_W-1:0] CTRL_RST = 8'h04;
    localparam logic [3:0] OFF_IEN  = 4'h0;
    localparam logic [3:0] OFF_STS  = 4'h4;
    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_IVAL = 4'h4;
    localparam logic [3:0] OFF_CNT  = 4'h8;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             pulse_o
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;

    // terminal value 2^n - 1, built by shifting an all-ones word
    assign lim     = {CNT_W{1'b1}} >> (EXP_W'(CNT_W) - exp_i);
    assign pulse_o = en_i && tick_i && (cnt_q == lim);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i && tick_i) begin
            cnt_d = pulse_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = 1 << SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              ival_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] ival_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic              expire_o
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] ival;
        logic [DATA_W-1:0] cnt;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic             run;
    logic [SRC_W-1:0] src_sel;
    logic [EXP_W-1:0] pre_exp;
    logic             sel_tick;
    logic             dec;
    logic             expire;

    assign run      = st_q.ctrl[CTL_EN];
    assign src_sel  = st_q.ctrl[CTL_SRC_LO +: SRC_W];
    assign pre_exp  = st_q.ctrl[CTL_EXP_LO +: EXP_W];
    assign sel_tick = src_tick[src_sel];

    tmr_prescale #(.EXP_W(EXP_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (ctrl_we),
        .en_i    (run),
        .tick_i  (sel_tick),
        .exp_i   (pre_exp),
        .pulse_o (dec)
    );

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (ctrl_we) begin
            st_d.ctrl = wdata[CTRL_W-1:0];
            if (wdata[CTL_RELOAD]) st_d.cnt = st_q.ival;
        end else if (dec) begin
            if (st_q.cnt == '0) begin
                expire = 1'b1;
                if (st_q.ctrl[CTL_ONESHOT]) st_d.ctrl[CTL_EN] = 1'b0;
                else                        st_d.cnt = st_q.ival;
            end else begin
                st_d.cnt = st_q.cnt - DATA_W'(1);
            end
        end
        if (ival_we) st_d.ival = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RST;
            st_q.ival <= '0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o   = st_q.ctrl;
    assign ival_o   = st_q.ival;
    assign cnt_o    = st_q.cnt;
    assign expire_o = expire;
endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 10,
    parameter int NUM_SRC = 1 << tmr_pkg::SRC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [NUM_CH-1:0]  irq
);
    localparam int WIN_W = ADDR_W - 4;

    typedef struct packed {
        logic [NUM_CH-1:0] ien;
        logic [NUM_CH-1:0] sts;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic [WIN_W-1:0] win;
    logic [3:0]       nib;
    logic [NUM_CH-1:0] ch_ctrl_we;
    logic [NUM_CH-1:0] ch_ival_we;
    logic [NUM_CH-1:0] ch_expire;
    logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_ival;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_cnt;
    logic sts_we, ien_we;

    assign win    = bus_addr[ADDR_W-1:4];
    assign nib    = bus_addr[3:0];
    assign ien_we = bus_wr && (win == '0) && (nib == OFF_IEN);
    assign sts_we = bus_wr && (win == '0) && (nib == OFF_STS);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_ctrl_we[g] = bus_wr && (win == WIN_W'(g + 1)) && (nib == OFF_CTRL);
        assign ch_ival_we[g] = bus_wr && (win == WIN_W'(g + 1)) && (nib == OFF_IVAL);

        tmr_channel #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (ch_ctrl_we[g]),
            .ival_we  (ch_ival_we[g]),
            .wdata    (bus_wdata),
            .src_tick (src_tick),
            .ctrl_o   (ch_ctrl[g]),
            .ival_o   (ch_ival[g]),
            .cnt_o    (ch_cnt[g]),
            .expire_o (ch_expire[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (ien_we) st_d.ien = bus_wdata[NUM_CH-1:0];
        // expiry set is applied after the clear so that it wins
        st_d.sts = (st_q.sts & ~(sts_we ? bus_wdata[NUM_CH-1:0] : '0)) | ch_expire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (win == '0) begin
            if (nib == OFF_IEN) bus_rdata = DATA_W'(st_q.ien);
            if (nib == OFF_STS) bus_rdata = DATA_W'(st_q.sts);
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (win == WIN_W'(i + 1)) begin
                if (nib == OFF_CTRL) bus_rdata = DATA_W'(ch_ctrl[i]);
                if (nib == OFF_IVAL) bus_rdata = ch_ival[i];
                if (nib == OFF_CNT)  bus_rdata = ch_cnt[i];
            end
        end
    end

    assign irq = st_q.sts & st_q.ien;
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    parameter int CTRL_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [NUM_CH-1:0]             irq,
    input logic [NUM_CH-1:0]             ien_q,
    input logic [NUM_CH-1:0]             sts_q,
    input logic [NUM_CH-1:0]             ch_expire,
    input logic [NUM_CH-1:0]             ch_ctrl_we,
    input logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl,
    input logic [NUM_CH-1:0][DATA_W-1:0] ch_cnt
);
    logic sts_wr;
    assign sts_wr = bus_wr && (bus_addr == ADDR_W'(4));

    // R8
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~ien_q) == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R8
        sts_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_wr && bus_wdata[g] && !ch_expire[g]) |=> !sts_q[g]);

        // R5
        sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_expire[g] |=> sts_q[g]);

        // R6
        oneshot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_expire[g] && ch_ctrl[g][7] && !ch_ctrl_we[g]) |=> !ch_ctrl[g][0]);

        // R4
        stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_ctrl[g][0] && !ch_ctrl_we[g]) |=> $stable(ch_cnt[g]));
    end
endmodule

bind interval_timer_bank tmr_bank_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CTRL_W (tmr_pkg::CTRL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq        (irq),
    .ien_q      (st_q.ien),
    .sts_q      (st_q.sts),
    .ch_expire  (ch_expire),
    .ch_ctrl_we (ch_ctrl_we),
    .ch_ctrl    (ch_ctrl),
    .ch_cnt     (ch_cnt)
);

// File: tb/interval_timer_bank_tb.sv
module interval_timer_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = '0;
    logic [5:0]  irq;

    int checks = 0;
    int errors = 0;
    string ptag = "";

    logic [7:0]  m_ctrl [NCH];
    logic [31:0] m_ival [NCH];
    logic [31:0] m_cnt  [NCH];
    int          m_pre  [NCH];
    logic [5:0]  m_ien, m_sts;

    interval_timer_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model_read(logic [9:0] a);
        int w = int'(a[9:4]);
        logic [3:0] n = a[3:0];
        if (w == 0) begin
            if (n == 4'h0) return {26'd0, m_ien};
            if (n == 4'h4) return {26'd0, m_sts};
            return 32'd0;
        end
        if (w >= 1 && w <= NCH) begin
            if (n == 4'h0) return {24'd0, m_ctrl[w-1]};
            if (n == 4'h4) return m_ival[w-1];
            if (n == 4'h8) return m_cnt[w-1];
        end
        return 32'd0;
    endfunction

    function automatic string tag_of(logic [9:0] a);
        int w = int'(a[9:4]);
        logic [3:0] n = a[3:0];
        if (ptag != "") return ptag;
        if (w == 0 && n == 4'h0) return "R7";
        if (w == 0 && n == 4'h4) return "R8";
        if (w >= 1 && w <= NCH && n == 4'h0) return "R3";
        if (w >= 1 && w <= NCH && n == 4'h4) return "R9";
        if (w >= 1 && w <= NCH && n == 4'h8) return "R4";
        return "R2";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_ctrl[i] = 8'h04; m_ival[i] = '0; m_cnt[i] = '0; m_pre[i] = 0;
        end
        m_ien = '0; m_sts = '0;
    endtask

    task automatic model_update(logic wr, logic [9:0] a, logic [31:0] wd, logic [3:0] tk);
        int w = int'(a[9:4]);
        logic [3:0] n = a[3:0];
        logic [5:0] expv = '0;
        for (int i = 0; i < NCH; i++) begin
            logic [7:0] c = m_ctrl[i];
            int lim = (1 << int'(c[6:4])) - 1;
            if (wr && w == i + 1 && n == 4'h0) begin
                m_ctrl[i] = wd[7:0];
                m_pre[i] = 0;
                if (wd[1]) m_cnt[i] = m_ival[i];
            end else if (c[0] && tk[c[3:2]]) begin
                if (m_pre[i] == lim) begin
                    m_pre[i] = 0;
                    if (m_cnt[i] == 0) begin
                        expv[i] = 1'b1;
                        if (c[7]) m_ctrl[i][0] = 1'b0;
                        else      m_cnt[i] = m_ival[i];
                    end else begin
                        m_cnt[i] = m_cnt[i] - 1;
                    end
                end else begin
                    m_pre[i] = m_pre[i] + 1;
                end
            end
            if (wr && w == i + 1 && n == 4'h4) m_ival[i] = wd;
        end
        if (wr && w == 0 && n == 4'h0) m_ien = wd[5:0];
        m_sts = (m_sts & ~((wr && w == 0 && n == 4'h4) ? wd[5:0] : 6'd0)) | expv;
    endtask

    task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, expv);
        end
    endtask

    // one cycle: drive at negedge, check combinational outputs, clock, update model
    task automatic step(logic wr, logic [9:0] a, logic [31:0] wd, logic [3:0] tk);
        bus_wr = wr; bus_addr = a; bus_wdata = wd; src_tick = tk;
        #1;
        check32(tag_of(a), $sformatf("read @0x%03h", a), bus_rdata, model_read(a));
        check32(ptag != "" ? ptag : "R7", "irq", {26'd0, irq}, {26'd0, m_sts & m_ien});
        @(posedge clk);
        model_update(wr, a, wd, tk);
        @(negedge clk);
        bus_wr = 1'b0; src_tick = '0;
    endtask

    task automatic rd(logic [9:0] a);
        step(1'b0, a, 32'd0, 4'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R1 watchdog: actual not done expected done");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        ptag = "R1";
        rd(10'h000); rd(10'h004);
        for (int i = 0; i < NCH; i++) begin
            rd(10'((i + 1) * 16)); rd(10'((i + 1) * 16 + 4)); rd(10'((i + 1) * 16 + 8));
        end

        // R6 one-shot on channel 0, source 0, no division
        ptag = "R6";
        step(1'b1, 10'h000, 32'h3F, 4'd0);
        step(1'b1, 10'h014, 32'd2, 4'd0);
        step(1'b1, 10'h010, 32'h83, 4'd0);
        for (int k = 0; k < 4; k++) step(1'b0, 10'h018, 32'd0, 4'b0001);
        rd(10'h010); rd(10'h004);
        check32("R6", "oneshot ctrl", {24'd0, m_ctrl[0]}, 32'h82);

        // R8 clear colliding with an expiry on channel 1 (periodic, interval 0)
        ptag = "R8";
        step(1'b1, 10'h024, 32'd0, 4'd0);
        step(1'b1, 10'h020, 32'h07, 4'd0);
        step(1'b1, 10'h004, 32'h3F, 4'b0010);
        rd(10'h004);
        step(1'b1, 10'h004, 32'h01, 4'd0);
        rd(10'h004);

        // R4 prescaler 2^2 on channel 2, source 2, plus stopped ticks
        ptag = "R4";
        step(1'b1, 10'h034, 32'd9, 4'd0);
        step(1'b1, 10'h030, 32'h29, 4'd0);
        for (int k = 0; k < 10; k++) step(1'b0, 10'h038, 32'd0, 4'b0100);
        step(1'b1, 10'h030, 32'h28, 4'd0);
        for (int k = 0; k < 4; k++) step(1'b0, 10'h038, 32'd0, 4'b1111);

        // R9 interval write keeps the count
        ptag = "R9";
        step(1'b1, 10'h034, 32'd77, 4'd0);
        rd(10'h038); rd(10'h034);

        // R2 unmapped and count writes ignored
        ptag = "R2";
        step(1'b1, 10'h00C, 32'hFFFF_FFFF, 4'd0);
        step(1'b1, 10'h3F0, 32'hFFFF_FFFF, 4'd0);
        step(1'b1, 10'h01C, 32'hFFFF_FFFF, 4'd0);
        step(1'b1, 10'h038, 32'h1234, 4'd0);
        rd(10'h00C); rd(10'h3F0); rd(10'h038); rd(10'h000); rd(10'h010);
        ptag = "";

        // R3 R5 constrained random mix
        for (int k = 0; k < 4000; k++) begin
            logic [9:0]  a;
            logic [31:0] wd;
            int sel = $urandom_range(0, 9);
            int ch  = $urandom_range(0, NCH - 1);
            wd = $urandom;
            case (sel)
                0: a = 10'h000;
                1: a = 10'h004;
                2, 3: begin
                    a = 10'((ch + 1) * 16);
                    wd[6] = 1'b0;
                    if ($urandom_range(0, 3) != 0) wd[5] = 1'b0;
                end
                4: begin a = 10'((ch + 1) * 16 + 4); wd = 32'($urandom_range(0, 12)); end
                5: a = 10'((ch + 1) * 16 + 8);
                6: a = 10'($urandom_range(0, 1023));
                default: a = 10'((ch + 1) * 16 + 8);
            endcase
            step(($urandom_range(0, 2) == 0) && sel <= 6, a, wd, 4'($urandom));
        end

        finish_run();
    end
endmodule